// File: doc/BRIEF.md
# Double-Buffered Waveform Playback Memory

This block stores the samples of an arbitrary waveform generator and plays them out. A 512-entry, 8-bit memory is split into two banks of 256 samples. The bank is chosen by the top address bit. One bank is the active bank, and it is read out over and over, one sample per playback clock cycle, into the DAC output register. The other bank is the shadow bank, and a slow host loads it through a parallel port.

On the host clock, the host drives an 8-bit data bus and four active-high controls:
- a write strobe;
- a pointer clear;
- a swap request;
- a playback enable level.

Each host control is registered in the host domain. Strobes are turned into toggles, and the toggles and the enable level pass through synchronizer flops into the playback clock domain. There an edge detector turns each toggle back into exactly one event.

A swap request does not act at once. It is held pending until the read pointer wraps from 255 to 0. The waveform period that is playing therefore always ends in full before the freshly loaded bank takes over.

Top module: `wave_pingpong_store`

## Requirements
- R1: Reset clears the DAC output to 0, makes bank 0 (address bit 8 = 0) the active bank and clears the read pointer, the pending swap and the load pointer. After reset, playback begins with the sample at bank 0, index 0.
- R2: A pointer-clear pulse (host_ptr_clr high for one host cycle) sets the load pointer to 0.
- R3: Each write pulse (host_wr_stb high for one host cycle) stores host_wdata exactly once, into the shadow bank at the load pointer, and then advances the pointer by one. Past index 255 the pointer wraps to 0 within the shadow bank.
- R4: Writes never change the samples of the active bank while it plays.
- R5: While enabled, the read pointer advances by one per playback cycle and cycles through indices 0 to 255. dac_out shows the active-bank sample of the pointer value from one cycle earlier.
- R6: A swap pulse (host_swap_req) is held pending and exchanges the banks only when the read pointer steps from 255 to 0. The sample after the old bank's index 255 is the new bank's index 0.
- R7: While the synchronized enable (host_play_en) is low, the read pointer and dac_out hold their values. When the enable returns high, stepping resumes from the held index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| host_clk | input | 1 | Slow host-side clock |
| host_rst | input | 1 | Synchronous active-high reset, host domain |
| host_wdata | input | 8 | Sample to be written, captured with the write pulse |
| host_wr_stb | input | 1 | One-cycle write pulse |
| host_ptr_clr | input | 1 | One-cycle pulse that clears the load pointer |
| host_swap_req | input | 1 | One-cycle pulse that requests a bank exchange |
| host_play_en | input | 1 | Playback enable level |
| play_clk | input | 1 | Fast playback clock |
| play_rst | input | 1 | Synchronous active-high reset, playback domain |
| dac_out | output | 8 | Registered sample for the DAC |

## Verification
The assertions rely on these conditions at the host inputs:
- Every host strobe lasts one host cycle and is followed by at least one idle host cycle, so the captured data stays steady while the playback domain samples it.
- Both resets are applied together, so no toggle is left behind that the edge detector would read as a stale event.
- A swap is requested only after the shadow load has finished.

The stimulus keeps within these conditions:
- Every pulse is issued by one task that always adds an idle cycle.
- Every swap is issued only once the preceding load has completed, and it is issued about 100 samples past a wrap, so the pending request is in place well before the boundary it must wait for.
- Reset is always asserted on both domains at once.

// File: rtl/wpb_pkg.sv
package wpb_pkg;

    parameter int SAMPLE_W = 8;
    parameter int BANK_AW  = 8;
    parameter int SYNC_N   = 2;

    localparam int MEM_AW     = BANK_AW + 1;
    localparam int BANK_DEPTH = 1 << BANK_AW;

    // bit positions of the host control word carried across domains
    localparam int CB_WR   = 0;
    localparam int CB_CLR  = 1;
    localparam int CB_SWAP = 2;
    localparam int CB_EN   = 3;
    localparam int CTRL_W  = 4;
    localparam int EVT_W   = 3;

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [BANK_AW-1:0]  slot_t;
    typedef logic [MEM_AW-1:0]   mem_addr_t;

    // one-cycle events in the playback domain; bit order follows CB_*
    typedef struct packed {
        logic swap;
        logic clr;
        logic wr;
    } host_evt_t;

    typedef enum logic {
        BANK_LO = 1'b0,
        BANK_HI = 1'b1
    } bank_e;

    function automatic mem_addr_t join_addr(input logic bank, input slot_t slot);
        return {bank, slot};
    endfunction

    function automatic logic is_last_slot(input slot_t slot);
        return slot == slot_t'(BANK_DEPTH - 1);
    endfunction

    function automatic bank_e other_bank(input bank_e b);
        return (b == BANK_LO) ? BANK_HI : BANK_LO;
    endfunction

endpackage

// File: rtl/wpb_sync.sv
module wpb_sync #(
    parameter int W = 4,
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [N];

    for (genvar i = 0; i < N; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= '0;
                else     stg[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[N-1];
endmodule

// File: rtl/wpb_host_if.sv
module wpb_host_if
    import wpb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  sample_t           wdata_in,
    input  logic              wr_in,
    input  logic              clr_in,
    input  logic              swap_in,
    input  logic              en_in,
    output sample_t           wdata_q,
    output logic [CTRL_W-1:0] ctrl_q
);
    logic wr_tgl, clr_tgl, swap_tgl, en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wdata_q  <= '0;
            wr_tgl   <= 1'b0;
            clr_tgl  <= 1'b0;
            swap_tgl <= 1'b0;
            en_q     <= 1'b0;
        end else begin
            en_q <= en_in;
            if (wr_in) begin
                wdata_q <= wdata_in;
                wr_tgl  <= ~wr_tgl;
            end
            if (clr_in)  clr_tgl  <= ~clr_tgl;
            if (swap_in) swap_tgl <= ~swap_tgl;
        end
    end

    always_comb begin
        ctrl_q          = '0;
        ctrl_q[CB_WR]   = wr_tgl;
        ctrl_q[CB_CLR]  = clr_tgl;
        ctrl_q[CB_SWAP] = swap_tgl;
        ctrl_q[CB_EN]   = en_q;
    end
endmodule

// File: rtl/wpb_cdc_rx.sv
module wpb_cdc_rx
    import wpb_pkg::*;
#(
    parameter int N = SYNC_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CTRL_W-1:0] ctrl_async,
    output host_evt_t         evt,
    output logic              play_en
);
    logic [CTRL_W-1:0] ctrl_s;
    logic [EVT_W-1:0]  tgl_prev;

    wpb_sync #(.W(CTRL_W), .N(N)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ctrl_async),
        .q   (ctrl_s)
    );

    always_ff @(posedge clk) begin
        if (rst) tgl_prev <= '0;
        else     tgl_prev <= ctrl_s[EVT_W-1:0];
    end

    assign evt     = host_evt_t'(ctrl_s[EVT_W-1:0] ^ tgl_prev);
    assign play_en = ctrl_s[CB_EN];
endmodule

// File: rtl/wpb_loader.sv
module wpb_loader
    import wpb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  host_evt_t evt,
    input  sample_t   host_wdata,
    output logic      we,
    output slot_t     waddr,
    output sample_t   wdata,
    output slot_t     wr_ptr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            we     <= 1'b0;
            waddr  <= '0;
            wdata  <= '0;
            wr_ptr <= '0;
        end else begin
            we <= evt.wr;
            if (evt.wr) begin
                waddr  <= wr_ptr;
                wdata  <= host_wdata;
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (evt.clr) wr_ptr <= '0;
        end
    end
endmodule

// File: rtl/wpb_player.sv
module wpb_player
    import wpb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  swap_evt,
    output slot_t rd_ptr,
    output bank_e bank_act,
    output logic  swap_pend,
    output logic  re
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr    <= '0;
            bank_act  <= BANK_LO;
            swap_pend <= 1'b0;
        end else begin
            if (swap_evt) swap_pend <= 1'b1;
            if (en) begin
                rd_ptr <= rd_ptr + 1'b1;
                if (is_last_slot(rd_ptr) && (swap_pend || swap_evt)) begin
                    bank_act  <= other_bank(bank_act);
                    swap_pend <= 1'b0;
                end
            end
        end
    end

    assign re = en;
endmodule

// File: rtl/wpb_dpram.sv
module wpb_dpram #(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/wave_pingpong_store.sv
module wave_pingpong_store
    import wpb_pkg::*;
#(
    parameter int SYNC_STAGES = SYNC_N
) (
    input  logic                host_clk,
    input  logic                host_rst,
    input  logic [SAMPLE_W-1:0] host_wdata,
    input  logic                host_wr_stb,
    input  logic                host_ptr_clr,
    input  logic                host_swap_req,
    input  logic                host_play_en,
    input  logic                play_clk,
    input  logic                play_rst,
    output logic [SAMPLE_W-1:0] dac_out
);
    sample_t           h_wdata_q;
    logic [CTRL_W-1:0] h_ctrl_q;
    host_evt_t         p_evt;
    logic              p_en;
    logic              ld_we;
    slot_t             ld_waddr;
    sample_t           ld_wdata;
    slot_t             wr_ptr;
    slot_t             rd_ptr;
    bank_e             bank_act;
    logic              swap_pend;
    logic              rd_en;
    mem_addr_t         ram_waddr;
    mem_addr_t         ram_raddr;

    wpb_host_if u_host (
        .clk      (host_clk),
        .rst      (host_rst),
        .wdata_in (host_wdata),
        .wr_in    (host_wr_stb),
        .clr_in   (host_ptr_clr),
        .swap_in  (host_swap_req),
        .en_in    (host_play_en),
        .wdata_q  (h_wdata_q),
        .ctrl_q   (h_ctrl_q)
    );

    wpb_cdc_rx #(.N(SYNC_STAGES)) u_rx (
        .clk        (play_clk),
        .rst        (play_rst),
        .ctrl_async (h_ctrl_q),
        .evt        (p_evt),
        .play_en    (p_en)
    );

    wpb_loader u_load (
        .clk        (play_clk),
        .rst        (play_rst),
        .evt        (p_evt),
        .host_wdata (h_wdata_q),
        .we         (ld_we),
        .waddr      (ld_waddr),
        .wdata      (ld_wdata),
        .wr_ptr     (wr_ptr)
    );

    wpb_player u_play (
        .clk       (play_clk),
        .rst       (play_rst),
        .en        (p_en),
        .swap_evt  (p_evt.swap),
        .rd_ptr    (rd_ptr),
        .bank_act  (bank_act),
        .swap_pend (swap_pend),
        .re        (rd_en)
    );

    assign ram_waddr = join_addr(other_bank(bank_act), ld_waddr);
    assign ram_raddr = join_addr(bank_act, rd_ptr);

    wpb_dpram #(.AW(MEM_AW), .DW(SAMPLE_W)) u_ram (
        .clk   (play_clk),
        .rst   (play_rst),
        .we    (ld_we),
        .waddr (ram_waddr),
        .wdata (ld_wdata),
        .re    (rd_en),
        .raddr (ram_raddr),
        .rdata (dac_out)
    );
endmodule

// File: rtl/wpb_checker.sv
module wpb_checker
    import wpb_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input logic    en,
    input logic    ev_wr,
    input logic    ev_clr,
    input slot_t   rd_ptr,
    input slot_t   wr_ptr,
    input logic    bank_bit,
    input logic    swap_pend,
    input sample_t dac
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (rd_ptr == '0 && !bank_bit && dac == '0 && !swap_pend && wr_ptr == '0));

    a_r2_clear_ptr: assert property (@(posedge clk) disable iff (rst)
        ev_clr |=> (wr_ptr == '0));

    a_r3_wr_advance: assert property (@(posedge clk) disable iff (rst)
        (ev_wr && !ev_clr) |=> (wr_ptr == $past(wr_ptr) + 1'b1));

    a_r5_read_step: assert property (@(posedge clk) disable iff (rst)
        en |=> (rd_ptr == $past(rd_ptr) + 1'b1));

    a_r6_swap_at_wrap: assert property (@(posedge clk) disable iff (rst)
        (bank_bit != $past(bank_bit)) |-> ($past(rd_ptr) == slot_t'(BANK_DEPTH - 1) && rd_ptr == '0));

    a_r6_pend_consumed: assert property (@(posedge clk) disable iff (rst)
        (bank_bit != $past(bank_bit)) |-> !swap_pend);

    a_r7_hold_off: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(rd_ptr) && $stable(dac) && $stable(bank_bit)));
endmodule

bind wave_pingpong_store wpb_checker u_wpb_chk (
    .clk       (play_clk),
    .rst       (play_rst),
    .en        (p_en),
    .ev_wr     (p_evt.wr),
    .ev_clr    (p_evt.clr),
    .rd_ptr    (rd_ptr),
    .wr_ptr    (wr_ptr),
    .bank_bit  (bank_act),
    .swap_pend (swap_pend),
    .dac       (dac_out)
);

// File: tb/wave_pingpong_store_tb_top.sv
module wave_pingpong_store_tb_top;

    logic       host_clk = 1'b0;
    logic       play_clk = 1'b0;
    logic       host_rst, play_rst;
    logic [7:0] host_wdata;
    logic       host_wr_stb, host_ptr_clr, host_swap_req, host_play_en;
    logic [7:0] dac_out;

    always #5  play_clk = ~play_clk;
    always #17 host_clk = ~host_clk;

    wave_pingpong_store dut_i (
        .host_clk      (host_clk),
        .host_rst      (host_rst),
        .host_wdata    (host_wdata),
        .host_wr_stb   (host_wr_stb),
        .host_ptr_clr  (host_ptr_clr),
        .host_swap_req (host_swap_req),
        .host_play_en  (host_play_en),
        .play_clk      (play_clk),
        .play_rst      (play_rst),
        .dac_out       (dac_out)
    );

    int         n_cmp = 0;
    int         n_bad = 0;
    bit         done  = 0;
    int         img [2][256];
    logic [7:0] cap [2048];

    task automatic chk(input bit ok, input string req, input int actual, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expv);
        end
    endtask

    // which: 0 write, 1 pointer clear, 2 swap; always one idle host cycle after
    task automatic hpulse(input int which);
        @(negedge host_clk);
        case (which)
            0: host_wr_stb   = 1'b1;
            1: host_ptr_clr  = 1'b1;
            default: host_swap_req = 1'b1;
        endcase
        @(negedge host_clk);
        host_wr_stb   = 1'b0;
        host_ptr_clr  = 1'b0;
        host_swap_req = 1'b0;
        @(negedge host_clk);
    endtask

    task automatic hwrite(input int v);
        host_wdata = v[7:0];
        hpulse(0);
    endtask

    task automatic capture(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge play_clk);
            cap[i] = dac_out;
        end
    endtask

    task automatic wait_idx(input int b, input int k);
        do @(negedge play_clk); while (dac_out !== img[b][k][7:0]);
    endtask

    // model: find phase in bank b, step one index per sample, apply a pending swap at wrap
    task automatic check_play(input int n, input int b0, input bit pend0, input string req);
        int  j = -1;
        int  b = b0;
        bit  pend = pend0;
        for (int k = 255; k >= 0; k--) if (img[b][k] == int'(cap[0])) j = k;
        chk(j >= 0, req, int'(cap[0]), img[b][0]);
        if (j < 0) return;
        for (int t = 1; t < n; t++) begin
            j = (j + 1) % 256;
            if (j == 0 && pend) begin
                b    = 1 - b;
                pend = 0;
            end
            chk(int'(cap[t]) == img[b][j], req, int'(cap[t]), img[b][j]);
        end
    endtask

    initial begin
        int t0;
        host_rst = 1'b1;  play_rst = 1'b1;
        host_wdata = '0;  host_wr_stb = 1'b0; host_ptr_clr = 1'b0;
        host_swap_req = 1'b0; host_play_en = 1'b0;
        for (int i = 0; i < 256; i++) begin
            img[1][i] = (7 * i + 3) % 256;
            img[0][i] = (3 * i + 100) % 256;
        end
        repeat (6) @(negedge host_clk);
        chk(dac_out == 8'd0, "R1 reset output", int'(dac_out), 0);
        host_rst = 1'b0; play_rst = 1'b0;
        repeat (10) @(negedge play_clk);
        chk(dac_out == 8'd0, "R7 disabled after reset", int'(dac_out), 0);

        // load bank 1 with a step-7 ramp, request swap while disabled, then enable
        hpulse(1);
        for (int i = 0; i < 256; i++) hwrite(img[1][i]);
        hpulse(2);
        host_play_en = 1'b1;
        repeat (700) @(negedge play_clk);
        capture(400);
        check_play(400, 1, 0, "R5 cyclic playback");

        // junk writes, pointer clear, full bank-0 load while bank 1 plays
        fork
            begin
                for (int i = 0; i < 5; i++) hwrite(8'hEE);
                hpulse(1);
                for (int i = 0; i < 256; i++) hwrite(img[0][i]);
            end
            capture(2000);
        join
        check_play(2000, 1, 0, "R4 active bank undisturbed");

        // swap mid-period: must wait for the wrap; also verifies R2 via bank-0 index 0
        wait_idx(1, 100);
        fork
            hpulse(2);
            capture(600);
        join
        check_play(600, 1, 1, "R6 swap at wrap / R2 pointer clear");

        // disable holds output and index
        host_play_en = 1'b0;
        repeat (30) @(negedge play_clk);
        capture(50);
        for (int t = 1; t < 50; t++)
            chk(cap[t] == cap[0], "R7 hold while disabled", int'(cap[t]), int'(cap[0]));
        host_play_en = 1'b1;
        repeat (30) @(negedge play_clk);
        capture(400);
        check_play(400, 0, 0, "R7 resume stepping");

        // load bank 1 with 258 writes: the last two wrap onto indices 0 and 1
        for (int i = 0; i < 256; i++) img[1][i] = (5 * i + 1) % 256;
        hpulse(1);
        for (int i = 0; i < 256; i++) hwrite(img[1][i]);
        hwrite(8'h11);
        hwrite(8'h22);
        img[1][0] = 8'h11;
        img[1][1] = 8'h22;
        wait_idx(0, 100);
        fork
            hpulse(2);
            capture(600);
        join
        check_play(600, 0, 1, "R3 write count and wrap");

        // reset during playback: output cleared, restart at bank 0 index 0
        @(negedge host_clk);
        host_rst = 1'b1; play_rst = 1'b1;
        repeat (4) @(negedge host_clk);
        @(negedge play_clk);
        chk(dac_out == 8'd0, "R1 reset mid-run", int'(dac_out), 0);
        @(negedge host_clk);
        host_rst = 1'b0; play_rst = 1'b0;
        capture(40);
        t0 = -1;
        for (int t = 39; t >= 0; t--) if (cap[t] != 8'd0) t0 = t;
        chk(t0 >= 0 && t0 < 10, "R1 restart latency", t0, 5);
        if (t0 >= 0 && t0 < 10)
            for (int k = 0; k < 20; k++)
                chk(int'(cap[t0 + k]) == img[0][k], "R1 restart from bank 0 index 0",
                    int'(cap[t0 + k]), img[0][k]);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge play_clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R5 watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule